// File: doc/BRIEF.md
# Pulse-Per-Second Output Generator

This block turns the live subsecond field of a precision time counter into a pulse train on one output pin. The pulses are aligned to second boundaries. Their rate is 2^N pulses per second, and N comes from a 4-bit select. The timestamp counter lives elsewhere. This block only samples the subsecond value that the counter presents each clock, and it works out the pulse level from that value.

The subsecond field is read in one of two ways. In binary mode it is a 31-bit fraction of a second that wraps at 2^31. In decimal mode it counts nanoseconds and wraps after one billion. At 1 pulse per second, the high time is one eighth of a second in binary mode and 100 ms in decimal mode. At higher binary rates the duty cycle is exactly half. At higher decimal rates the pulses come from a nanosecond bit, so the waveform is uneven. The number of pulses in each second is still exact.

Top module: `pps_gen`

## Requirements
- R1: While reset is asserted, and after it, `ppsOut` is low. The active rate select resets to 0, which means 1 pulse per second, before any second boundary is seen.
- R2: In binary mode (`decimalMode`=0) with active select 0, the pulse is high while `subSec[30:28]` are all zero. That is 1/8 of each second, starting at the boundary.
- R3: In binary mode with active select N from 1 to 15, the pulse level is the inverse of `subSec[30-N]`. This gives 2^N pulses per second at exactly 50% duty.
- R4: In decimal mode with active select 0, the pulse is high while `subSec` is below 100,000,000.
- R5: In decimal mode with active select N from 1 to 15, the pulse level is the inverse of `subSec[28-N]`. It is forced high in the cycle where a second boundary is seen. Once 2^N pulses have ended within a second, the level stays low until the next boundary. Each second has exactly 2^N rising edges.
- R6: When `ppsEnable` is low, `ppsOut` is low one clock later. Pulse generation continues internally.
- R7: `freqSel` is taken at a second boundary and applies from that boundary cycle on. A change in the middle of a second has no effect until the next boundary.
- R8: `ppsOut` is a register. It shows the level computed from the inputs presented one clock earlier.
- R9: A second boundary is detected when `subSec` is lower than its value on the previous clock. This holds in both modes, whatever the wrap value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ppsEnable | input | 1 | Drives the pin when high; holds the pin low when low |
| decimalMode | input | 1 | 0: binary subsecond field; 1: nanosecond field wrapping at 10^9 |
| freqSel | input | 4 | Rate exponent N; the output runs at 2^N pulses per second |
| subSec | input | 31 | Live subsecond value of the time counter |
| ppsOut | output | 1 | Registered pulse output |

## Verification
Every result is due exactly one clock after the subsecond value that causes it, because the only register between the inputs and the pin is the output register. A new rate select shows up in the first sample after the next decrease of `subSec`. The bench drives inputs on falling edges and samples `ppsOut` on the next falling edge. Sample k of a measured second therefore belongs to drive k-1. On that basis the bench checks high-cycle counts, rising-edge counts, and the first and last high sample of each second against values worked out from the requirements.

// File: rtl/pps_pkg.sv
package pps_pkg;
  // Width of the rate exponent field.
  localparam int PPS_SEL_W = 4;

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic                 wrap;      // second boundary seen in this cycle
    logic [PPS_SEL_W-1:0] sel;       // rate exponent in force this cycle
    logic                 gateOpen;  // decimal mode: pulse budget not used up
  } ppsStrobe_t;
endpackage

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
#(
  parameter int SUBSEC_W = 31
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SUBSEC_W-1:0]  subSec,
  input  logic [PPS_SEL_W-1:0] freqSel,
  input  logic                 decimalMode,
  input  logic                 levelNow,
  output ppsStrobe_t           strobe
);
  localparam int MAX_EXP = (1 << PPS_SEL_W) - 1;
  localparam int CNT_W   = MAX_EXP + 1;

  logic [SUBSEC_W-1:0]  prevSub;
  logic [PPS_SEL_W-1:0] activeSel;
  logic [PPS_SEL_W-1:0] curSel;
  logic [CNT_W-1:0]     fallCnt;
  logic [CNT_W-1:0]     pulseLimit;
  logic                 levelPrev;
  logic                 wrapNow;
  logic                 countOn;

  // A boundary is any drop of the subsecond value (R9).
  assign wrapNow    = subSec < prevSub;
  assign curSel     = wrapNow ? freqSel : activeSel;
  assign pulseLimit = CNT_W'(1) << curSel;
  assign countOn    = decimalMode && (curSel != '0);

  assign strobe.wrap     = wrapNow;
  assign strobe.sel      = curSel;
  assign strobe.gateOpen = fallCnt < pulseLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSub   <= '0;
      activeSel <= '0;
      fallCnt   <= '0;
      levelPrev <= 1'b0;
    end else begin
      prevSub   <= subSec;
      levelPrev <= levelNow;
      if (wrapNow) begin
        activeSel <= freqSel;
        fallCnt   <= '0;
      end else if (countOn && levelPrev && !levelNow && (fallCnt < pulseLimit)) begin
        fallCnt <= fallCnt + CNT_W'(1);
      end
    end
  end

  // R7: the selection only moves at a boundary.
  a_r7_sel_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wrapNow |=> $stable(activeSel));

  // R5: completed pulses never exceed the budget of the second.
  a_r5_count_cap: assert property (@(posedge clk) disable iff (!rstN)
    fallCnt <= (CNT_W'(1) << activeSel));
endmodule

// File: rtl/pps_datapath.sv
module pps_datapath
  import pps_pkg::*;
#(
  parameter int SUBSEC_W     = 31,
  parameter int DIG_TOP      = 28,
  parameter int DIG_WIDTH_NS = 100_000_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SUBSEC_W-1:0] subSec,
  input  logic                decimalMode,
  input  logic                enable,
  input  ppsStrobe_t          strobe,
  output logic                levelNow,
  output logic                ppsOut
);
  localparam int MAX_EXP   = (1 << PPS_SEL_W) - 1;
  localparam int TOP_BITS  = 3;
  localparam logic [SUBSEC_W-1:0] DIG_WIDTH_L = SUBSEC_W'(DIG_WIDTH_NS);

  logic [MAX_EXP:0] binTap;
  logic [MAX_EXP:0] digTap;
  logic             binLevel;
  logic             digLevel;

  assign binTap[0] = 1'b0;
  assign digTap[0] = 1'b0;

  // One inverted subsecond bit per selectable rate, for each mode.
  for (genvar k = 1; k <= MAX_EXP; k++) begin : g_tap
    assign binTap[k] = ~subSec[SUBSEC_W-1-k];
    assign digTap[k] = ~subSec[DIG_TOP-k];
  end

  always_comb begin
    if (strobe.sel == '0) begin
      binLevel = (subSec[SUBSEC_W-1 -: TOP_BITS] == '0);
      digLevel = (subSec < DIG_WIDTH_L);
    end else begin
      binLevel = binTap[strobe.sel];
      digLevel = strobe.wrap | (digTap[strobe.sel] & strobe.gateOpen);
    end
  end

  assign levelNow = decimalMode ? digLevel : binLevel;

  always_ff @(posedge clk) begin
    if (!rstN) ppsOut <= 1'b0;
    else       ppsOut <= enable & levelNow;
  end

  // R6: disabled pin is low on the next clock.
  a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !ppsOut);

  // R2: binary 1 Hz pulse during the first eighth of the second.
  a_r2_bin_first_eighth: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !decimalMode && strobe.sel == '0 &&
     subSec[SUBSEC_W-1 -: TOP_BITS] == '0) |=> ppsOut);

  // R3: binary higher rates follow the selected bit.
  a_r3_bin_tap_low: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !decimalMode && strobe.sel != '0 &&
     subSec[SUBSEC_W-1-int'(strobe.sel)]) |=> !ppsOut);

  // R4: decimal 1 Hz pulse below the width threshold.
  a_r4_dec_width: assert property (@(posedge clk) disable iff (!rstN)
    (enable && decimalMode && strobe.sel == '0 && subSec < DIG_WIDTH_L) |=> ppsOut);

  // R5: decimal higher rates start every second with a high level.
  a_r5_dec_boundary_high: assert property (@(posedge clk) disable iff (!rstN)
    (enable && decimalMode && strobe.wrap && strobe.sel != '0) |=> ppsOut);
endmodule

// File: rtl/pps_gen.sv
module pps_gen
  import pps_pkg::*;
#(
  parameter int SUBSEC_W     = 31,
  parameter int DIGITAL_WRAP = 1_000_000_000,
  parameter int DIG_WIDTH_NS = 100_000_000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ppsEnable,
  input  logic                 decimalMode,
  input  logic [PPS_SEL_W-1:0] freqSel,
  input  logic [SUBSEC_W-1:0]  subSec,
  output logic                 ppsOut
);
  // Highest nanosecond bit below the wrap value, minus one, sets the tap base.
  localparam int DIG_TOP = $clog2(DIGITAL_WRAP) - 2;

  ppsStrobe_t strobe;
  logic       levelNow;

  pps_ctrl #(.SUBSEC_W(SUBSEC_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .subSec     (subSec),
    .freqSel    (freqSel),
    .decimalMode(decimalMode),
    .levelNow   (levelNow),
    .strobe     (strobe)
  );

  pps_datapath #(
    .SUBSEC_W    (SUBSEC_W),
    .DIG_TOP     (DIG_TOP),
    .DIG_WIDTH_NS(DIG_WIDTH_NS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .subSec     (subSec),
    .decimalMode(decimalMode),
    .enable     (ppsEnable),
    .strobe     (strobe),
    .levelNow   (levelNow),
    .ppsOut     (ppsOut)
  );
endmodule

// File: tb/pps_gen_tb.sv
module pps_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ppsEnable = 1'b0;
  logic        decimalMode = 1'b0;
  logic [3:0]  freqSel = 4'd0;
  logic [30:0] subSec = '0;
  logic        ppsOut;

  logic [30:0] nextSub = '0;
  int checks = 0;
  int errors = 0;

  localparam logic [30:0] BIN_STEP = 31'(1 << 21);   // 1024 clocks per second
  localparam logic [30:0] DEC_STEP = 31'(1_000_000); // 1000 clocks per second
  localparam logic [30:0] DEC_WRAP = 31'(1_000_000_000);

  always #2 clk = ~clk;

  pps_gen dut_i (
    .clk(clk), .rstN(rstN), .ppsEnable(ppsEnable), .decimalMode(decimalMode),
    .freqSel(freqSel), .subSec(subSec), .ppsOut(ppsOut)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic advanceNext();
    if (decimalMode) nextSub = (nextSub + DEC_STEP >= DEC_WRAP) ? '0 : nextSub + DEC_STEP;
    else             nextSub = nextSub + BIN_STEP;
  endtask

  task automatic driveOne();
    @(negedge clk);
    subSec = nextSub;
    advanceNext();
  endtask

  task automatic align();
    while (nextSub != '0) driveOne();
  endtask

  // Measures one second. Sample i reflects the drive made at i-1.
  task automatic measure(input int changeAt, input logic [3:0] newSel,
                         output int highs, output int rises,
                         output int firstHigh, output int lastHigh);
    int n = decimalMode ? 1000 : 1024;
    logic last = 1'b0;
    highs = 0; rises = 0; firstHigh = -1; lastHigh = -1;
    align();
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if (ppsOut) begin
          highs++;
          if (firstHigh < 0) firstHigh = i;
          lastHigh = i;
        end
        if (ppsOut && !last) rises++;
      end
      last = ppsOut;
      if (i == changeAt) freqSel = newSel;
      if (i < n) begin
        subSec = nextSub;
        advanceNext();
      end
    end
  endtask

  task automatic testReset();
    int highs;
    highs = 0;
    ppsEnable = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (ppsOut) highs++;
    end
    checkEq("R1", "high samples during reset", highs, 0);
    @(negedge clk);
    rstN = 1'b1;
    ppsEnable = 1'b0;
    for (int i = 0; i < 5; i++) begin
      driveOne();
      if (ppsOut) highs++;
    end
    checkEq("R1", "high samples after reset while disabled", highs, 0);
    ppsEnable = 1'b1;
  endtask

  task automatic testBinOneHz();
    int h, r, f, l;
    measure(-1, 4'd0, h, r, f, l);
    checkEq("R1", "default rate rises", r, 1);
    checkEq("R2", "binary 1 Hz high cycles", h, 128);
    checkEq("R8", "first high sample", f, 1);
    checkEq("R8", "last high sample", l, 128);
  endtask

  task automatic testBinRates();
    int h, r, f, l;
    int exps [4] = '{1, 2, 3, 8};
    foreach (exps[j]) begin
      freqSel = 4'(exps[j]);
      measure(-1, 4'd0, h, r, f, l);
      checkEq("R3", $sformatf("binary 2^%0d rises", exps[j]), r, 1 << exps[j]);
      checkEq("R3", $sformatf("binary 2^%0d high cycles", exps[j]), h, 512);
    end
  endtask

  task automatic testSelChange();
    int h, r, f, l;
    freqSel = 4'd0;
    measure(-1, 4'd0, h, r, f, l);
    measure(300, 4'd2, h, r, f, l);
    checkEq("R7", "rises in second of mid-change", r, 1);
    checkEq("R7", "high cycles in second of mid-change", h, 128);
    measure(-1, 4'd0, h, r, f, l);
    checkEq("R7", "rises after boundary", r, 4);
    checkEq("R7", "high cycles after boundary", h, 512);
  endtask

  task automatic testEnable();
    int h, r, f, l;
    freqSel = 4'd0;
    measure(-1, 4'd0, h, r, f, l);
    ppsEnable = 1'b0;
    measure(-1, 4'd0, h, r, f, l);
    checkEq("R6", "high cycles while disabled", h, 0);
    ppsEnable = 1'b1;
    measure(-1, 4'd0, h, r, f, l);
    checkEq("R6", "high cycles after re-enable", h, 128);
  endtask

  task automatic enterDecimal();
    decimalMode = 1'b1;
    nextSub = '0;
  endtask

  task automatic testDecOneHz();
    int h, r, f, l;
    freqSel = 4'd0;
    enterDecimal();
    measure(-1, 4'd0, h, r, f, l);
    checkEq("R4", "decimal 1 Hz high cycles", h, 100);
    checkEq("R4", "decimal 1 Hz rises", r, 1);
    checkEq("R4", "decimal 1 Hz first high sample", f, 1);
  endtask

  task automatic testDecRates();
    int h, r, f, l;
    freqSel = 4'd2;
    measure(-1, 4'd0, h, r, f, l);
    checkEq("R5", "decimal 2^2 rises", r, 4);
    checkEq("R5", "decimal 2^2 last high sample", l, 470);
    freqSel = 4'd3;
    measure(-1, 4'd0, h, r, f, l);
    checkEq("R5", "decimal 2^3 rises", r, 8);
    checkEq("R5", "decimal 2^3 last high sample", l, 504);
  endtask

  task automatic testDecBoundary();
    int h, r, f, l;
    freqSel = 4'd0;
    measure(-1, 4'd0, h, r, f, l);
    measure(300, 4'd2, h, r, f, l);
    checkEq("R9", "decimal rises before wrap", r, 1);
    measure(-1, 4'd0, h, r, f, l);
    checkEq("R9", "decimal rises after 10^9 wrap", r, 4);
  endtask

  initial begin
    testReset();
    testBinOneHz();
    testBinRates();
    testSelChange();
    testEnable();
    testDecOneHz();
    testDecRates();
    testDecBoundary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule